// File: doc/BRIEF.md
# Handshake Request Edge Counter

This block paces a memory-to-memory transfer engine from an external request pin, such as the read strobe of an external FIFO. It holds a signed count of block transfers that are still owed. Each qualifying edge of the pin adds one to the count, and each block-done strobe from the engine subtracts one. While the count is above zero and the block is armed, it raises a transfer request toward the engine.

Arming the block loads a signed start value. A positive value grants that many transfers at once, with no pin activity. For example, loading the depth of a downstream FIFO fills that FIFO first, and after that each read strobe allows one more word. A negative value makes the block absorb that many pin edges before it requests anything. A zero value waits for the first edge. The pin is asynchronous, so it passes through a synchronizer first, and the edge direction that counts is selectable.

Top module: `hs_req_pacer`

## Requirements
- R1: After reset, `pend_count` is 0 and `xfer_req` is low.
- R2: On the first clock edge where `arm_en` is high after being low, `pend_count` loads `start_count`. No pin edge and no done strobe is applied on that edge.
- R3: With a start value of 0, `xfer_req` stays low until a qualifying pin edge has raised `pend_count` to 1.
- R4: With a positive start value N, `xfer_req` is high from the cycle after arming, and it falls after N `blk_done` strobes.
- R5: With a negative start value -M, the first M qualifying edges only raise the count toward 0. `xfer_req` first rises on edge M+1.
- R6: With `rise_sel` = 1, only 0-to-1 transitions of `req_pin` count. With `rise_sel` = 0, only 1-to-0 transitions count.
- R7: A qualifying edge and a `blk_done` strobe that act on the same clock edge leave `pend_count` unchanged.
- R8: `pend_count` saturates at +32767 (16'h7FFF) and at -32768 (16'h8000), and it never wraps.
- R9: While `arm_en` is low, pin edges and `blk_done` are ignored, `pend_count` holds its value, and `xfer_req` is low.
- R10: A single transition of `req_pin` moves `pend_count` by exactly one step. The step shows up on the third rising clock edge after the transition, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_en | input | 1 | Arms the block; a 0-to-1 change reloads the count |
| rise_sel | input | 1 | 1 = count rising pin edges, 0 = count falling pin edges |
| start_count | input | 16 | Signed two's-complement start value |
| req_pin | input | 1 | Asynchronous external request pin |
| blk_done | input | 1 | One-cycle strobe from the engine per finished block |
| xfer_req | output | 1 | Transfer request toward the engine |
| pend_count | output | 16 | Live signed pending count |

## Verification
A synchronized pin edge and an engine done strobe can act on the same clock edge. The bench provokes this by raising `blk_done` exactly two cycles after it moves the pin, so both reach the counter together. It then expects the count to be unchanged. The same timing with only one of the two events present must move the count by one step, which separates a correct merge from a dropped event.

// File: rtl/hs_pacer_pkg.sv
// Package: shared defaults and the step command used between the
// edge logic and the pending counter.
package hs_pacer_pkg;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;
endpackage

// File: rtl/hs_pin_sync.sv
// Module: hs_pin_sync
// Brings the asynchronous request pin into the clock domain through
// SYNC_STAGES flops, then flags one cycle per qualifying transition.
// Assumes: SYNC_STAGES >= 2; rise_sel is quasi-static.
module hs_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // First synchronizer stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_async;
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            // Each further stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Holds the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    // Picks the transition direction that counts.
    always_comb begin
        if (rise_sel) edge_hit = chain_q[SYNC_STAGES-1] & ~last_q;
        else          edge_hit = ~chain_q[SYNC_STAGES-1] & last_q;
    end
endmodule

// File: rtl/hs_arm_ctl.sv
// Module: hs_arm_ctl
// Tracks the arm input: one load pulse on its rising change, and a run
// level on every later armed cycle.
// Assumes: arm_en is synchronous to clk.
module hs_arm_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_en,
    output logic load_pulse,
    output logic running
);
    logic arm_q;

    // Remembers the arm level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_en;
    end

    // Splits the arm level into a load cycle and run cycles.
    always_comb begin
        load_pulse = arm_en & ~arm_q;
        running    = arm_en &  arm_q;
    end
endmodule

// File: rtl/hs_pend_cnt.sv
// Module: hs_pend_cnt
// Signed saturating counter of owed transfers. A load takes priority
// over a step; the step saturates at the signed limits.
// Assumes: step is only non-HOLD while the block runs.
module hs_pend_cnt
    import hs_pacer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  step_e            step,
    output logic [CNT_W-1:0] count,
    output logic             positive
);
    localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Computes the next count from load, step and the limits.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else begin
            case (step)
                STEP_UP:   if (cnt_q != MAX_V) cnt_d = cnt_q + ONE_V;
                STEP_DOWN: if (cnt_q != MIN_V) cnt_d = cnt_q - ONE_V;
                default:   cnt_d = cnt_q;
            endcase
        end
    end

    // Holds the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Publishes the count and its above-zero flag.
    always_comb begin
        count    = cnt_q;
        positive = ~cnt_q[CNT_W-1] & (|cnt_q);
    end
endmodule

// File: rtl/hs_req_pacer.sv
// Module: hs_req_pacer (top)
// Paces a transfer engine from an external request pin: synchronized pin
// edges add to a signed owed count, done strobes subtract from it, and the
// request is high while armed with a positive count.
// Assumes: blk_done is a single-cycle strobe in the clk domain.
module hs_req_pacer
    import hs_pacer_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_en,
    input  logic             rise_sel,
    input  logic [CNT_W-1:0] start_count,
    input  logic             req_pin,
    input  logic             blk_done,
    output logic             xfer_req,
    output logic [CNT_W-1:0] pend_count
);
    logic  edge_hit;
    logic  load_pulse;
    logic  running;
    logic  cnt_pos;
    step_e step;

    hs_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (req_pin),
        .rise_sel  (rise_sel),
        .edge_hit  (edge_hit)
    );

    hs_arm_ctl u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_en     (arm_en),
        .load_pulse (load_pulse),
        .running    (running)
    );

    // Merges edge and done into one step; both at once cancel out.
    always_comb begin
        step = STEP_HOLD;
        if (running) begin
            if (edge_hit && !blk_done)      step = STEP_UP;
            else if (!edge_hit && blk_done) step = STEP_DOWN;
        end
    end

    hs_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .load_val (start_count),
        .step     (step),
        .count    (pend_count),
        .positive (cnt_pos)
    );

    // Request only while running with transfers owed.
    always_comb xfer_req = running & cnt_pos;
endmodule

// File: rtl/hs_req_pacer_chk.sv
// Module: hs_req_pacer_chk
// Property checker bound to hs_req_pacer.
module hs_req_pacer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_en,
    input logic [CNT_W-1:0] start_count,
    input logic             xfer_req,
    input logic [CNT_W-1:0] pend_count
);
    localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

    logic arm_seen;
    // Tracks the arm level as seen by the checker since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_seen <= 1'b0;
        else        arm_seen <= arm_en;
    end

    // R2
    load_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_en && !arm_seen) |=> (pend_count == $past(start_count)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_en |=> $stable(pend_count));

    // R3
    req_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (arm_en && !pend_count[CNT_W-1] && pend_count != '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_en && arm_seen && pend_count == MAX_V) |=> (pend_count != MIN_V));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_en && arm_seen && pend_count == MIN_V) |=> (pend_count != MAX_V));

    // R10
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_en && arm_seen) |=>
            ((pend_count == $past(pend_count)) ||
             (pend_count == $past(pend_count) + 1'b1) ||
             (pend_count == $past(pend_count) - 1'b1)));
endmodule

bind hs_req_pacer hs_req_pacer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_en      (arm_en),
    .start_count (start_count),
    .xfer_req    (xfer_req),
    .pend_count  (pend_count)
);

// File: tb/hs_req_pacer_tb_top.sv
module hs_req_pacer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_en = 1'b0;
    logic        rise_sel = 1'b1;
    logic [15:0] start_count = '0;
    logic        req_pin = 1'b0;
    logic        blk_done = 1'b0;
    logic        xfer_req;
    logic [15:0] pend_count;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    hs_req_pacer dut_i (
        .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .rise_sel(rise_sel),
        .start_count(start_count), .req_pin(req_pin), .blk_done(blk_done),
        .xfer_req(xfer_req), .pend_count(pend_count)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Driver side: queue an expectation and wait until the monitor took it.
    task automatic expect_out(input string tag, input logic [15:0] c, input logic r);
        exp_t e;
        e.tag = tag; e.cnt = c; e.req = r;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic pin_to(input logic v);
        req_pin = v;
        tick(3);
    endtask

    task automatic done_pulse();
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
    endtask

    task automatic arm(input logic [15:0] v);
        arm_en = 1'b0;
        tick(1);
        start_count = v;
        arm_en = 1'b1;
        tick(1);
    endtask

    // Monitor: compares queued expectations on the falling clock edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pend_count !== e.cnt || xfer_req !== e.req) begin
                errors++;
                $display("FAIL %s: count=%h req=%b expected count=%h req=%b",
                         e.tag, pend_count, xfer_req, e.cnt, e.req);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_out("R1 reset", 16'h0000, 1'b0);
        rst_n = 1'b1;
        tick(1);

        // R2 / R3: zero start, rising edges
        rise_sel = 1'b1;
        arm(16'h0000);
        expect_out("R2 load zero", 16'h0000, 1'b0);
        req_pin = 1'b1;
        tick(2);
        expect_out("R10 no step before third edge", 16'h0000, 1'b0);
        tick(1);
        expect_out("R3 first edge grants", 16'h0001, 1'b1);
        pin_to(1'b0);
        expect_out("R6 falling ignored when rising selected", 16'h0001, 1'b1);
        done_pulse();
        expect_out("R3 done consumes", 16'h0000, 1'b0);

        // R6: falling polarity
        arm_en = 1'b0;
        tick(1);
        rise_sel = 1'b0;
        arm(16'h0000);
        pin_to(1'b1);
        expect_out("R6 rising ignored when falling selected", 16'h0000, 1'b0);
        pin_to(1'b0);
        expect_out("R6 falling counted", 16'h0001, 1'b1);

        // R7: edge and done on the same clock edge
        pin_to(1'b1);
        req_pin = 1'b0;
        tick(2);
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        expect_out("R7 edge plus done", 16'h0001, 1'b1);
        done_pulse();
        expect_out("R7 done alone steps", 16'h0000, 1'b0);
        pin_to(1'b1);
        pin_to(1'b0);
        expect_out("R10 one transition one step", 16'h0001, 1'b1);

        // R9: disarmed holds
        arm_en = 1'b0;
        tick(1);
        expect_out("R9 request drops", 16'h0001, 1'b0);
        pin_to(1'b1);
        pin_to(1'b0);
        done_pulse();
        expect_out("R9 count holds", 16'h0001, 1'b0);

        // R4: positive start
        rise_sel = 1'b1;
        arm(16'd3);
        expect_out("R4 pre-granted", 16'd3, 1'b1);
        done_pulse();
        done_pulse();
        expect_out("R4 after two", 16'd1, 1'b1);
        done_pulse();
        expect_out("R4 exhausted", 16'd0, 1'b0);

        // R5: negative start absorbs edges
        arm(16'hFFFE);
        expect_out("R2 load negative", 16'hFFFE, 1'b0);
        pin_to(1'b1);
        expect_out("R5 first absorbed", 16'hFFFF, 1'b0);
        pin_to(1'b0);
        pin_to(1'b1);
        expect_out("R5 second absorbed", 16'h0000, 1'b0);
        pin_to(1'b0);
        pin_to(1'b1);
        expect_out("R5 third grants", 16'h0001, 1'b1);

        // R8: saturation
        arm(16'h7FFF);
        pin_to(1'b0);
        pin_to(1'b1);
        expect_out("R8 top saturates", 16'h7FFF, 1'b1);
        arm(16'h8000);
        done_pulse();
        expect_out("R8 bottom saturates", 16'h8000, 1'b0);

        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule